// File: doc/BRIEF.md
# Five-Channel Compare Timer

The block holds a free-running time-base counter that advances by one on every clock and can be reloaded by software. Up to five compare channels watch the counter. Each channel has a compare value and a don't-care mask. When the counter first agrees with a channel's compare value on every unmasked bit, that channel's status bit is set. An interrupt line is high while the status bit and the matching interrupt-mask bit are both set. When a channel's output is enabled, its pin carries a programmed level while the channel matches and the inverse of that level while it does not.

Software uses a simple 32-bit register port. Only full-word accesses, with all four byte enables set, take effect. Reads return their data one clock later, with a response strobe. Register offsets are: counter 0x00, output enable 0x10, output level 0x14, interrupt mask 0x20, status 0x24 (a read returns status, a write sets bits), status clear 0x28 (write only) and interrupt enable 0x2C. Compare registers are at 0x80 + 4·n and mask registers at 0xC0 + 4·n. The window ends at 0xD4.

Top module: `ctm_top`

## Requirements
- R1: After reset, the counter, output enable, output level, interrupt mask, status, interrupt enable and every compare and mask register read as zero, and all pins and interrupt lines are low.
- R2: The counter rises by one on every clock. A write to offset 0x00 loads the written value, and a read returns the value held on the clock edge that accepts the read.
- R3: The output-enable and output-level registers keep only bits 31:27, with channel n at bit 31−n. The interrupt mask, status and interrupt-enable registers keep only bits 15:11, with channel n at bit 15−n. All other bits read as zero.
- R4: The compare register of channel n is at 0x80 + 4·n and its mask register is at 0xC0 + 4·n. Both are full counter width. Reads of unmapped offsets, and of any offset at or above 0xD4, return zero.
- R5: A channel matches when the counter and its compare value are equal on every bit where its mask bit is 0. Bits where the mask bit is 1 are ignored.
- R6: A channel's status bit is set on the clock after the first cycle of a match. It is not set again while the match persists. A match that already holds when reset is released does not count.
- R7: Writing to 0x24 ORs the channel bits of the written word into status. Writing to 0x28 clears the status bits whose channel bits are 1. A hardware match event in the same cycle as a clear wins.
- R8: Interrupt line n is high exactly while status bit n and interrupt-mask bit n are both 1. The interrupt-enable register is stored and readable but does not gate the lines.
- R9: Pin n is low while output enable n is 0. When it is enabled, the pin equals output level n while channel n matches and the inverse of that level otherwise.
- R10: An access whose byte enables are not all ones has no effect: a write changes nothing and a read gets no response.
- R11: A legal read produces the response strobe, with its data, exactly one clock after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_be | input | 4 | Byte enables; only 4'b1111 is legal |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe |
| tmr_out | output | NCH | Channel output pins |
| tmr_irq | output | NCH | Channel interrupt lines |

## Verification
A wrong match decode, or a wrong edge detector, shows up on the status register and the interrupt line one clock after the counter enters or leaves the compare window. A status bit that is set again while a match persists is visible on the first read after a clear. Pin polarity errors appear in the same cycle as the register write or the counter change, because the pins are combinational from registered state. A reversed bit-to-channel mapping is caught by reading back fields and by driving single channels one at a time.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
   localparam int unsigned NCH_LIMIT = 5;
   localparam int unsigned HI_TOP    = 31;
   localparam int unsigned LO_TOP    = 15;

   localparam logic [7:0] OFS_COUNT    = 8'h00;
   localparam logic [7:0] OFS_OUT_EN   = 8'h10;
   localparam logic [7:0] OFS_OUT_LVL  = 8'h14;
   localparam logic [7:0] OFS_IRQ_MASK = 8'h20;
   localparam logic [7:0] OFS_STAT_SET = 8'h24;
   localparam logic [7:0] OFS_STAT_CLR = 8'h28;
   localparam logic [7:0] OFS_IRQ_EN   = 8'h2C;
   localparam logic [7:0] OFS_CMP_BASE = 8'h80;
   localparam logic [7:0] OFS_MSK_BASE = 8'hC0;

   typedef struct packed {
      logic        wr;
      logic        rd;
      logic [7:0]  addr;
      logic [31:0] data;
   } acc_t;
endpackage

// File: rtl/ctm_chan.sv
module ctm_chan #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp,
   input  logic [CNT_W-1:0] msk,
   input  logic             oe,
   input  logic             lvl,
   output logic             evt,
   output logic             pin
);
   logic hit, hit_q;

   // equal on every bit whose mask bit is clear
   assign hit = ((cnt ^ cmp) & ~msk) == '0;

   // reset to 1 so a match already present at reset release is not an event
   always_ff @(posedge clk) begin
      if (!rst_n) hit_q <= 1'b1;
      else        hit_q <= hit;
   end

   assign evt = hit & ~hit_q;
   assign pin = oe & (hit ? lvl : ~lvl);
endmodule

// File: rtl/ctm_regs.sv
module ctm_regs
   import ctm_pkg::*;
#(
   parameter int unsigned NCH   = 5,
   parameter int unsigned CNT_W = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  acc_t                       acc,
   input  logic [NCH-1:0]             hit_evt,
   output logic [CNT_W-1:0]           cnt_q,
   output logic [NCH-1:0][CNT_W-1:0]  cmp_q,
   output logic [NCH-1:0][CNT_W-1:0]  msk_q,
   output logic [NCH-1:0]             oe_q,
   output logic [NCH-1:0]             ol_q,
   output logic [NCH-1:0]             imask_q,
   output logic [NCH-1:0]             stat_q,
   output logic [NCH-1:0]             ien_q,
   output logic [31:0]                rdata_q,
   output logic                       rvalid_q
);
   function automatic logic [NCH-1:0] take_field(logic [31:0] d, int unsigned top);
      logic [NCH-1:0] r;
      for (int i = 0; i < NCH; i++) r[i] = d[top-i];
      return r;
   endfunction

   function automatic logic [31:0] give_field(logic [NCH-1:0] v, int unsigned top);
      logic [31:0] r;
      r = '0;
      for (int i = 0; i < NCH; i++) r[top-i] = v[i];
      return r;
   endfunction

   logic wr_cnt, wr_oe, wr_ol, wr_im, wr_set, wr_clr, wr_ien;
   logic [NCH-1:0] lo_bits, hi_bits, set_v, clr_v, stat_nxt;
   logic [31:0] rd_mux;

   assign wr_cnt = acc.wr && acc.addr == OFS_COUNT;
   assign wr_oe  = acc.wr && acc.addr == OFS_OUT_EN;
   assign wr_ol  = acc.wr && acc.addr == OFS_OUT_LVL;
   assign wr_im  = acc.wr && acc.addr == OFS_IRQ_MASK;
   assign wr_set = acc.wr && acc.addr == OFS_STAT_SET;
   assign wr_clr = acc.wr && acc.addr == OFS_STAT_CLR;
   assign wr_ien = acc.wr && acc.addr == OFS_IRQ_EN;

   assign lo_bits = take_field(acc.data, LO_TOP);
   assign hi_bits = take_field(acc.data, HI_TOP);
   assign set_v   = wr_set ? lo_bits : '0;
   assign clr_v   = wr_clr ? lo_bits : '0;
   // hardware events are ORed after the clear so none is lost
   assign stat_nxt = (stat_q & ~clr_v) | set_v | hit_evt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         oe_q    <= '0;
         ol_q    <= '0;
         imask_q <= '0;
         stat_q  <= '0;
         ien_q   <= '0;
      end else begin
         cnt_q  <= wr_cnt ? acc.data[CNT_W-1:0] : cnt_q + 1'b1;
         stat_q <= stat_nxt;
         if (wr_oe)  oe_q    <= hi_bits;
         if (wr_ol)  ol_q    <= hi_bits;
         if (wr_im)  imask_q <= lo_bits;
         if (wr_ien) ien_q   <= lo_bits;
      end
   end

   for (genvar g = 0; g < NCH; g++) begin : g_cmp
      localparam logic [7:0] CMP_OFS = OFS_CMP_BASE + 8'(4 * g);
      localparam logic [7:0] MSK_OFS = OFS_MSK_BASE + 8'(4 * g);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cmp_q[g] <= '0;
            msk_q[g] <= '0;
         end else begin
            if (acc.wr && acc.addr == CMP_OFS) cmp_q[g] <= acc.data[CNT_W-1:0];
            if (acc.wr && acc.addr == MSK_OFS) msk_q[g] <= acc.data[CNT_W-1:0];
         end
      end
   end

   always_comb begin
      rd_mux = '0;
      case (acc.addr)
         OFS_COUNT:    rd_mux = 32'(cnt_q);
         OFS_OUT_EN:   rd_mux = give_field(oe_q, HI_TOP);
         OFS_OUT_LVL:  rd_mux = give_field(ol_q, HI_TOP);
         OFS_IRQ_MASK: rd_mux = give_field(imask_q, LO_TOP);
         OFS_STAT_SET: rd_mux = give_field(stat_q, LO_TOP);
         OFS_IRQ_EN:   rd_mux = give_field(ien_q, LO_TOP);
         default: begin
            for (int i = 0; i < NCH; i++) begin
               if (acc.addr == OFS_CMP_BASE + 8'(4 * i)) rd_mux = 32'(cmp_q[i]);
               if (acc.addr == OFS_MSK_BASE + 8'(4 * i)) rd_mux = 32'(msk_q[i]);
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= acc.rd;
         if (acc.rd) rdata_q <= rd_mux;
      end
   end
endmodule

// File: rtl/ctm_top.sv
module ctm_top
   import ctm_pkg::*;
#(
   parameter int unsigned NCH   = 5,
   parameter int unsigned CNT_W = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           bus_valid,
   input  logic           bus_write,
   input  logic [7:0]     bus_addr,
   input  logic [3:0]     bus_be,
   input  logic [31:0]    bus_wdata,
   output logic [31:0]    bus_rdata,
   output logic           bus_rvalid,
   output logic [NCH-1:0] tmr_out,
   output logic [NCH-1:0] tmr_irq
);
   if (NCH < 1 || NCH > NCH_LIMIT) begin : g_bad_nch
      $error("ctm_top: NCH must be 1..5");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cntw
      $error("ctm_top: CNT_W must be 2..32");
   end

   acc_t acc;
   logic legal;
   logic [CNT_W-1:0]          cnt_q;
   logic [NCH-1:0][CNT_W-1:0] cmp_q, msk_q;
   logic [NCH-1:0]            oe_q, ol_q, imask_q, stat_q, ien_q, hit_evt;

   assign legal    = bus_valid && bus_be == 4'hF;
   assign acc.wr   = legal && bus_write;
   assign acc.rd   = legal && !bus_write;
   assign acc.addr = bus_addr;
   assign acc.data = bus_wdata;

   ctm_regs #(.NCH(NCH), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .acc(acc), .hit_evt(hit_evt),
      .cnt_q(cnt_q), .cmp_q(cmp_q), .msk_q(msk_q),
      .oe_q(oe_q), .ol_q(ol_q), .imask_q(imask_q), .stat_q(stat_q), .ien_q(ien_q),
      .rdata_q(bus_rdata), .rvalid_q(bus_rvalid)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_chan
      ctm_chan #(.CNT_W(CNT_W)) u_chan (
         .clk(clk), .rst_n(rst_n), .cnt(cnt_q),
         .cmp(cmp_q[g]), .msk(msk_q[g]),
         .oe(oe_q[g]), .lvl(ol_q[g]),
         .evt(hit_evt[g]), .pin(tmr_out[g])
      );
   end

   assign tmr_irq = stat_q & imask_q;
endmodule

// File: rtl/ctm_chk.sv
module ctm_chk
   import ctm_pkg::*;
#(
   parameter int unsigned NCH   = 5,
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_valid,
   input logic             bus_write,
   input logic [7:0]       bus_addr,
   input logic [3:0]       bus_be,
   input logic [31:0]      bus_wdata,
   input logic             bus_rvalid,
   input logic [NCH-1:0]   tmr_out,
   input logic [NCH-1:0]   tmr_irq,
   input logic [CNT_W-1:0] cnt_q,
   input logic [NCH-1:0]   stat_q,
   input logic [NCH-1:0]   imask_q,
   input logic [NCH-1:0]   oe_q,
   input logic [NCH-1:0]   hit_evt
);
   logic ok_rd, ok_wr, cnt_ld;
   logic [NCH-1:0] sw_set;

   assign ok_rd  = bus_valid && !bus_write && bus_be == 4'hF;
   assign ok_wr  = bus_valid && bus_write && bus_be == 4'hF;
   assign cnt_ld = ok_wr && bus_addr == OFS_COUNT;
   always_comb begin
      sw_set = '0;
      if (ok_wr && bus_addr == OFS_STAT_SET)
         for (int i = 0; i < NCH; i++) sw_set[i] = bus_wdata[LO_TOP-i];
   end

   // R11
   rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ok_rd |=> bus_rvalid);
   // R10
   no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ok_rd |=> !bus_rvalid);
   // R10
   bad_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && bus_be != 4'hF) |=> ($stable(oe_q) && $stable(imask_q)));
   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_ld |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
   // R2
   cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_ld |=> cnt_q == $past(bus_wdata[CNT_W-1:0]));
   // R6
   stat_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_q & ~$past(stat_q)) & ~($past(hit_evt) | $past(sw_set))) == '0);
   // R8
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_irq & ~$past(tmr_irq)) != '0 |-> (stat_q != $past(stat_q) || imask_q != $past(imask_q)));
   // R9
   pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_out & ~oe_q) == '0);
endmodule

bind ctm_top ctm_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
   .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
   .bus_rvalid(bus_rvalid), .tmr_out(tmr_out), .tmr_irq(tmr_irq),
   .cnt_q(cnt_q), .stat_q(stat_q), .imask_q(imask_q), .oe_q(oe_q),
   .hit_evt(hit_evt)
);

// File: tb/test_ctm_top.sv
`timescale 1ns/1ps
module test_ctm_top;
   localparam int NCH = 5;
   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_valid = 1'b0, bus_write = 1'b0;
   logic [7:0] bus_addr = '0;
   logic [3:0] bus_be = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic bus_rvalid;
   logic [NCH-1:0] tmr_out, tmr_irq;
   int n_chk = 0, n_err = 0;
   logic [31:0] rv;
   logic got;

   always #2.5 clk = ~clk;

   ctm_top #(.NCH(NCH), .CNT_W(32)) i_ctm_top (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
      .tmr_out(tmr_out), .tmr_irq(tmr_irq)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // tasks are entered at a falling edge and return at a falling edge
   task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d, output logic ok, input logic [3:0] be = 4'hF);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_be = be;
      @(negedge clk);
      d = bus_rdata; ok = bus_rvalid;
      bus_valid = 1'b0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R1 pins in reset", 32'(tmr_out), 0);
      chk("R1 irq in reset", 32'(tmr_irq), 0);
      rst_n = 1'b1;
      rd(8'h00, rv, got); chk("R1 counter", rv, 0);
      rd(8'h10, rv, got); chk("R1 out enable", rv, 0);
      rd(8'h14, rv, got); chk("R1 out level", rv, 0);
      rd(8'h20, rv, got); chk("R1 irq mask", rv, 0);
      rd(8'h24, rv, got); chk("R1 status", rv, 0);
      rd(8'h2C, rv, got); chk("R1 irq enable", rv, 0);
      rd(8'h8C, rv, got); chk("R1 compare3", rv, 0);
      rd(8'hD0, rv, got); chk("R1 mask4", rv, 0);
   endtask

   task automatic t_counter;
      wr(8'h00, 32'd100);
      rd(8'h00, rv, got);
      chk("R11 rvalid", 32'(got), 1);
      chk("R2 load", rv, 32'd100);
      idle(3);
      rd(8'h00, rv, got); chk("R2 increment", rv, 32'd104);
   endtask

   task automatic t_fields;
      wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, rv, got); chk("R3 out enable bits", rv, 32'hF800_0000);
      wr(8'h14, 32'h1234_5678); rd(8'h14, rv, got); chk("R3 out level bits", rv, 32'h1000_0000);
      wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, rv, got); chk("R3 irq mask bits", rv, 32'h0000_F800);
      wr(8'h2C, 32'h0000_A5A5); rd(8'h2C, rv, got); chk("R3 irq enable bits", rv, 32'h0000_A000);
      wr(8'h90, 32'hDEAD_BEEF); rd(8'h90, rv, got); chk("R4 compare4", rv, 32'hDEAD_BEEF);
      wr(8'hC8, 32'h0F0F_0F0F); rd(8'hC8, rv, got); chk("R4 mask2", rv, 32'h0F0F_0F0F);
      rd(8'hD4, rv, got); chk("R4 out of window", rv, 0);
      rd(8'h30, rv, got); chk("R4 unmapped", rv, 0);
      wr(8'h10, 0); wr(8'h14, 0); wr(8'h20, 0); wr(8'h2C, 0);
      wr(8'h90, 0); wr(8'hC8, 0);
      wr(8'h28, 32'hFFFF_FFFF);
   endtask

   task automatic t_match;
      wr(8'h88, 32'd1000);
      wr(8'h20, 32'h0000_2000);
      wr(8'h00, 32'd990);
      wr(8'h28, 32'hFFFF_FFFF);
      chk("R8 irq before match", 32'(tmr_irq), 0);
      idle(20);
      rd(8'h24, rv, got); chk("R6 status ch2 on match", rv, 32'h0000_2000);
      chk("R8 irq ch2", 32'(tmr_irq), 32'h04);
      wr(8'h28, 32'h0000_2000);
      chk("R7 clear drops irq", 32'(tmr_irq), 0);
      wr(8'h88, 0); wr(8'h20, 0);
   endtask

   task automatic t_mask;
      wr(8'h84, 32'h0000_2000);
      wr(8'hC4, 32'h0000_00FF);
      wr(8'h00, 32'h0000_1FF0);
      wr(8'h28, 32'hFFFF_FFFF);
      rd(8'h24, rv, got); chk("R5 no match outside window", rv, 0);
      idle(30);
      rd(8'h24, rv, got); chk("R5 masked match ch1", rv, 32'h0000_4000);
      wr(8'h28, 32'h0000_4000);
      idle(10);
      rd(8'h24, rv, got); chk("R6 no re-set while matching", rv, 0);
      wr(8'h84, 0); wr(8'hC4, 0);
      wr(8'h28, 32'hFFFF_FFFF);
   endtask

   task automatic t_swset;
      wr(8'h2C, 32'h0000_F800);
      wr(8'h24, 32'hFFFF_FFFF);
      rd(8'h24, rv, got); chk("R7 set status", rv, 32'h0000_F800);
      chk("R8 mask zero gates irq, enable no effect", 32'(tmr_irq), 0);
      wr(8'h20, 32'h0000_8800);
      chk("R8 irq ch0 ch4", 32'(tmr_irq), 32'h11);
      wr(8'h28, 32'h0000_8000);
      rd(8'h24, rv, got); chk("R7 clear ch0", rv, 32'h0000_7800);
      chk("R8 irq ch4 only", 32'(tmr_irq), 32'h10);
      wr(8'h28, 32'hFFFF_FFFF);
      chk("R7 clear all", 32'(tmr_irq), 0);
      wr(8'h20, 0); wr(8'h2C, 0);
   endtask

   task automatic t_pins;
      wr(8'h8C, 32'hFFFF_0000);
      wr(8'h14, 32'h1000_0000);
      chk("R9 disabled pin low", 32'(tmr_out), 0);
      wr(8'h14, 0);
      wr(8'h10, 32'h1000_0000);
      chk("R9 no match inverse of level 0", 32'(tmr_out), 32'h08);
      wr(8'hCC, 32'hFFFF_FFFF);
      chk("R9 match gives level 0", 32'(tmr_out), 0);
      wr(8'h14, 32'h1000_0000);
      chk("R9 match gives level 1", 32'(tmr_out), 32'h08);
      wr(8'h10, 0);
      chk("R9 enable cleared", 32'(tmr_out), 0);
      wr(8'hCC, 0); wr(8'h8C, 0); wr(8'h14, 0);
      wr(8'h28, 32'hFFFF_FFFF);
   endtask

   task automatic t_badbe;
      wr(8'h10, 32'hFFFF_FFFF, 4'b0111);
      rd(8'h10, rv, got); chk("R10 partial write ignored", rv, 0);
      wr(8'h24, 32'hFFFF_FFFF, 4'b1110);
      rd(8'h24, rv, got); chk("R10 partial status set ignored", rv, 0);
      rd(8'h00, rv, got, 4'b1100);
      chk("R10 partial read no response", 32'(got), 0);
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      #750000;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      idle(4);
      t_reset();
      t_counter();
      t_fields();
      t_match();
      t_mask();
      t_swset();
      t_pins();
      t_badbe();
      idle(2);
      finish_run();
   end
endmodule